// File: doc/BRIEF.md
# Floating-point control and status word

This block holds the single 32-bit word through which a floating-point unit is configured and through which it reports what happened. Software writes the whole word at once and reads it back at any time. The arithmetic datapath uses it in three ways. It reports exceptions at the end of each completed operation, and these accumulate as sticky flags. It reports each comparison result, which enters a history queue. It takes the current rounding direction and flush-to-zero selection from the word.

When a completed operation raises an exception whose trap enable is set, the block asserts a trap request in the same cycle. It also records a delayed-trap mark in the word at the next edge. A software write in the same cycle as a hardware update overrides that update, because every write replaces every writable field.

Word layout:

| Bits | Contents |
|------|----------|
| 31..27 | Sticky flags |
| 26 | Newest comparison result |
| 25..22 | Reserved |
| 21..11 | Older comparison results, newest at bit 21 |
| 10..9 | Rounding direction |
| 8..7 | Reserved |
| 6 | Delayed-trap mark |
| 5 | Flush-to-zero |
| 4..0 | Trap enables, in the same order as the flags |

Top module: `fpcsr_top`

## Requirements
- R1: A synchronous active-low reset clears the whole word to 0x00000000. This gives round-to-nearest, flush-to-zero off, all trap enables off, and `trapReq` low.
- R2: A write (`wrEn` high) stores `wrData` masked with 0xFC3FFE7F at the next edge. Bits 25..22 and 8..7 always read as zero.
- R3: When `opDone` is high, each set bit of `opExc` is ORed into a sticky flag. The mapping is `opExc[4]` invalid to bit 31, `opExc[3]` divide-by-zero to bit 30, `opExc[2]` overflow to bit 29, `opExc[1]` underflow to bit 28, and `opExc[0]` inexact to bit 27. A flag is cleared only by a write.
- R4: When `cmpValid` is high, `cmpResult` is loaded into bit 26. The old bit 26 moves to bit 21, and bits 21..12 move down one place to bits 20..11. The old bit 11 is discarded, so a result leaves the word after the twelfth later compare.
- R5: `roundMode` always equals bits 10..9 (00 nearest, 01 toward zero, 10 toward +infinity, 11 toward -infinity). `flushZero` always equals bit 5.
- R6: `trapReq` is high in the same cycle exactly when `opDone` is high and `opExc` ANDed with trap enables bits 4..0 is nonzero.
- R7: When `trapReq` is high and no write occurs, bit 6 is set at the next edge and the sticky flags are still updated. Bit 6 then holds until a write.
- R8: A write in the same cycle as an exception report, a compare or a trap overrides all of them. The next word is the masked write data.
- R9: `opExc` has no effect while `opDone` is low, and `cmpResult` has no effect while `cmpValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Whole-word write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current word |
| opDone | input | 1 | An operation completed this cycle |
| opExc | input | 5 | Exceptions of that operation (invalid, div0, overflow, underflow, inexact from bit 4 down) |
| cmpValid | input | 1 | A comparison completed this cycle |
| cmpResult | input | 1 | Result of that comparison |
| roundMode | output | 2 | Rounding direction to the datapath |
| flushZero | output | 1 | Flush-to-zero selection to the datapath |
| trapReq | output | 1 | Enabled exception reported this cycle |

## Verification
The assertions assume that all inputs are known from the first edge after reset. They also assume that the datapath's strobes are single-cycle qualifiers: `opExc` and `cmpResult` carry meaning only in cycles where `opDone` or `cmpValid` is high. The stimulus changes inputs only on the falling edge and returns every strobe to zero after its cycle. Garbage is driven on `opExc` and `cmpResult` only when their qualifiers are low, which tests R9 without breaking the assumptions that the other properties rely on.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int WORD_W = 32;
  localparam int FLAG_W = 5;
  localparam int HIST_W = 11;
  localparam int RND_W  = 2;

  localparam int FLAG_LSB = 27;
  localparam int CMP_BIT  = 26;
  localparam int HIST_LSB = 11;
  localparam int RND_LSB  = 9;
  localparam int TRAP_BIT = 6;
  localparam int FTZ_BIT  = 5;
  localparam int EN_LSB   = 0;

  localparam logic [WORD_W-1:0] WRITE_MASK = 32'hFC3F_FE7F;

  typedef enum logic [RND_W-1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_POS     = 2'b10,
    RND_NEG     = 2'b11
  } roundDir_e;

  typedef struct packed {
    logic doWrite;
    logic doSticky;
    logic doShift;
    logic doTrapMark;
  } ctlStrobes_t;
endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
(
  input  logic              wrEn,
  input  logic              opDone,
  input  logic [FLAG_W-1:0] opExc,
  input  logic              cmpValid,
  input  logic [FLAG_W-1:0] trapEn,
  output ctlStrobes_t       strobes,
  output logic              trapReq
);
  logic [FLAG_W-1:0] enabledExc;

  always_comb begin
    enabledExc = opDone ? (opExc & trapEn) : '0;
    trapReq    = |enabledExc;
    // software write overrides every hardware update
    strobes.doWrite    = wrEn;
    strobes.doSticky   = opDone   & ~wrEn;
    strobes.doShift    = cmpValid & ~wrEn;
    strobes.doTrapMark = trapReq  & ~wrEn;
  end
endmodule

// File: rtl/fpcsr_datapath.sv
module fpcsr_datapath
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic [FLAG_W-1:0] opExc,
  input  logic              cmpResult,
  output logic [WORD_W-1:0] word,
  output logic [FLAG_W-1:0] trapEn,
  output roundDir_e         rndDir,
  output logic              ftz
);
  logic [FLAG_W-1:0] flags;
  logic              cmpNew;
  logic [HIST_W-1:0] hist;
  logic              trapMark;
  logic [FLAG_W-1:0] flagsNext;

  genvar g;
  generate
    for (g = 0; g < FLAG_W; g++) begin : g_sticky
      always_comb flagsNext[g] = flags[g] | (strobes.doSticky & opExc[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags    <= '0;
      cmpNew   <= 1'b0;
      hist     <= '0;
      rndDir   <= RND_NEAREST;
      trapMark <= 1'b0;
      ftz      <= 1'b0;
      trapEn   <= '0;
    end else if (strobes.doWrite) begin
      flags    <= wrData[FLAG_LSB +: FLAG_W];
      cmpNew   <= wrData[CMP_BIT];
      hist     <= wrData[HIST_LSB +: HIST_W];
      rndDir   <= roundDir_e'(wrData[RND_LSB +: RND_W]);
      trapMark <= wrData[TRAP_BIT];
      ftz      <= wrData[FTZ_BIT];
      trapEn   <= wrData[EN_LSB +: FLAG_W];
    end else begin
      flags <= flagsNext;
      if (strobes.doShift) begin
        hist   <= {cmpNew, hist[HIST_W-1:1]};
        cmpNew <= cmpResult;
      end
      if (strobes.doTrapMark) trapMark <= 1'b1;
    end
  end

  always_comb begin
    word = '0;
    word[FLAG_LSB +: FLAG_W] = flags;
    word[CMP_BIT]            = cmpNew;
    word[HIST_LSB +: HIST_W] = hist;
    word[RND_LSB +: RND_W]   = rndDir;
    word[TRAP_BIT]           = trapMark;
    word[FTZ_BIT]            = ftz;
    word[EN_LSB +: FLAG_W]   = trapEn;
  end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        opDone,
  input  logic [4:0]  opExc,
  input  logic        cmpValid,
  input  logic        cmpResult,
  output logic [1:0]  roundMode,
  output logic        flushZero,
  output logic        trapReq
);
  ctlStrobes_t       strobes;
  logic [FLAG_W-1:0] trapEn;
  roundDir_e         rndDir;

  fpcsr_ctrl u_ctrl (
    .wrEn     (wrEn),
    .opDone   (opDone),
    .opExc    (opExc),
    .cmpValid (cmpValid),
    .trapEn   (trapEn),
    .strobes  (strobes),
    .trapReq  (trapReq)
  );

  fpcsr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .opExc     (opExc),
    .cmpResult (cmpResult),
    .word      (rdData),
    .trapEn    (trapEn),
    .rndDir    (rndDir),
    .ftz       (flushZero)
  );

  assign roundMode = rndDir;
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        opDone,
  input logic [4:0]  opExc,
  input logic        cmpValid,
  input logic        cmpResult,
  input logic [1:0]  roundMode,
  input logic        flushZero,
  input logic        trapReq
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (rdData == 32'h0 && !trapReq));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[25:22] == 4'h0 && rdData[8:7] == 2'h0));

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((rdData[31:27] & $past(rdData[31:27])) == $past(rdData[31:27])));

  p_cmp_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !wrEn) |=> (rdData[26] == $past(cmpResult) &&
                             rdData[21] == $past(rdData[26]) &&
                             rdData[20:11] == $past(rdData[21:12])));

  p_controls_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    (roundMode == rdData[10:9] && flushZero == rdData[5]));

  p_trap_needs_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (opDone && (opExc & rdData[4:0]) != 5'h0));

  p_trap_mark_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !wrEn) |=> rdData[6]);

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == ($past(wrData) & 32'hFC3F_FE7F)));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !opDone && !cmpValid) |=> $stable(rdData));
endmodule

bind fpcsr_top fpcsr_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .opDone    (opDone),
  .opExc     (opExc),
  .cmpValid  (cmpValid),
  .cmpResult (cmpResult),
  .roundMode (roundMode),
  .flushZero (flushZero),
  .trapReq   (trapReq)
);

// File: tb/fpcsr_top_tb.sv
`timescale 1ns/1ps
module fpcsr_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        opDone = 1'b0;
  logic [4:0]  opExc = '0;
  logic        cmpValid = 1'b0;
  logic        cmpResult = 1'b0;
  logic [1:0]  roundMode;
  logic        flushZero;
  logic        trapReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fpcsr_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .opDone(opDone), .opExc(opExc), .cmpValid(cmpValid), .cmpResult(cmpResult),
    .roundMode(roundMode), .flushZero(flushZero), .trapReq(trapReq)
  );

  // {wrEn, wrData, opDone, opExc, cmpValid, cmpResult, expTrap, expRd}
  localparam int NV = 15;
  localparam logic [73:0] VECS [NV] = '{
    {1'b1, 32'hFFFF_FFFF, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 32'hFC3F_FE7F}, // R2 mask
    {1'b1, 32'h0000_0000, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 32'h0000_0000}, // R2 clear
    {1'b0, 32'h0,         1'b1, 5'h11, 1'b0, 1'b0, 1'b0, 32'h8800_0000}, // R3 invalid+inexact
    {1'b0, 32'h0,         1'b1, 5'h04, 1'b0, 1'b0, 1'b0, 32'hA800_0000}, // R3 overflow, sticky
    {1'b0, 32'h0,         1'b0, 5'h1F, 1'b0, 1'b1, 1'b0, 32'hA800_0000}, // R9 unqualified
    {1'b0, 32'h0,         1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 32'hAC00_0000}, // R4 first compare
    {1'b0, 32'h0,         1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 32'hA820_0000}, // R4 shift to 21
    {1'b0, 32'h0,         1'b0, 5'h00, 1'b1, 1'b1, 1'b0, 32'hAC10_0000}, // R4 shift to 20
    {1'b0, 32'h0,         1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 32'hAC10_0000}, // R9 cmpResult ignored
    {1'b1, 32'h0000_061F, 1'b1, 5'h1F, 1'b0, 1'b0, 1'b0, 32'h0000_061F}, // R8 write beats flags
    {1'b0, 32'h0,         1'b1, 5'h02, 1'b0, 1'b0, 1'b1, 32'h1000_065F}, // R6 R7 underflow trap
    {1'b0, 32'h0,         1'b1, 5'h00, 1'b0, 1'b0, 1'b0, 32'h1000_065F}, // R6 no exception
    {1'b1, 32'h0000_0021, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 32'h0000_0021}, // R5 flush-to-zero
    {1'b0, 32'h0,         1'b1, 5'h08, 1'b0, 1'b0, 1'b0, 32'h4000_0021}, // R6 disabled div0
    {1'b1, 32'h0000_0000, 1'b1, 5'h01, 1'b1, 1'b1, 1'b1, 32'h0000_0000}  // R8 write beats trap+cmp
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrData = '0; opDone = 0; opExc = '0; cmpValid = 0; cmpResult = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset word", rdData, 32'h0);
    chk("R1 reset trap", {31'b0, trapReq}, 32'h0);
    chk("R1 reset round", {30'b0, roundMode}, 32'h0);
    @(negedge clk);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wrEn, wrData, opDone, opExc, cmpValid, cmpResult} = VECS[i][73:33];
      #1;
      chk($sformatf("R6 trap row %0d", i), {31'b0, trapReq}, {31'b0, VECS[i][32]});
      @(posedge clk);
      #1;
      chk($sformatf("R2 R3 R4 R7 R8 R9 word row %0d", i), rdData, VECS[i][31:0]);
      if (i == 9)  chk("R5 round toward -inf", {30'b0, roundMode}, 32'h3);
      if (i == 12) chk("R5 flush-to-zero out", {31'b0, flushZero}, 32'h1);
      @(negedge clk);
      idle();
    end

    // R4 depth: fill history with ones, then push zeros
    @(negedge clk);
    wrEn = 1; wrData = 32'h043F_F800;
    @(negedge clk);
    idle();
    for (int k = 1; k <= 12; k++) begin
      cmpValid = 1; cmpResult = 0;
      @(posedge clk);
      #1;
      if (k == 11) chk("R4 oldest survives 11 compares", rdData, 32'h0000_0800);
      if (k == 12) chk("R4 oldest dropped on 12th", rdData, 32'h0);
      @(negedge clk);
      idle();
    end

    // R7 mark persists until written
    @(negedge clk);
    wrEn = 1; wrData = 32'h0000_0010;
    @(negedge clk);
    wrEn = 0; opDone = 1; opExc = 5'h10;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk("R7 mark and flag held", rdData, 32'h8000_0050);

    // R1 mid-run reset
    @(negedge clk);
    rstN = 0; opDone = 1; opExc = 5'h1F;
    @(posedge clk);
    #1;
    chk("R1 reset overrides update", rdData, 32'h0);
    chk("R1 trap low after reset", {31'b0, trapReq}, 32'h0);
    @(negedge clk);
    idle();
    rstN = 1;
    @(negedge clk);
    finish_run();
  end
endmodule